// File: doc/BRIEF.md
# Programmable-Level Priority Arbiter

This block picks one of eight DMA channels to own the transfer path. Software gives every channel its own 4-bit urgency level. The block uses those levels when a global mode input selects fixed ordering. Only channels that are both requesting and enabled compete. Among them, the smallest level value wins. When two or more candidates have the same level, the channel with the smallest number wins.

The winner is given a registered one-hot grant together with its binary channel number. The grant stays in place until the transfer-done input reports that the current transfer has finished. No arbitration happens while a grant is active. When the mode input is 1, the levels are ignored and plain channel-number order decides; this stands in for a rotating scheme.

Top module: `prio_level_arbiter`

## Requirements
- R1: In fixed mode (`mode_rot`=0), the candidate with the numerically smallest level is granted: level 0 is the most urgent and level 15 the least. The level of channel i is `chan_lvl[4*i+3:4*i]`.
- R2: In fixed mode, among candidates with equal level, the lowest channel number is granted. For example, channels 1 and 5 at the same level give a grant to channel 1.
- R3: A channel whose `chan_en` bit is 0 never wins, whatever its request or level.
- R4: While a grant is active and `xfer_done` is 0, `grant` and `grant_idx` stay unchanged, even when requests, enables, levels or mode change.
- R5: `xfer_done`=1 during an active grant clears the grant at that clock edge. The inputs in the following cycle are then arbitrated, and the new grant appears at the next edge.
- R6: With `mode_rot`=1, the lowest-numbered enabled requesting channel is granted and the levels have no effect.
- R7: `grant` is one-hot or all zero, and `grant[grant_idx]` is set whenever `grant` is nonzero. When no grant is active, `grant_idx` is 0. An idle cycle with no enabled requester leaves `grant` at zero.
- R8: A synchronous active-high `rst` drives `grant` and `grant_idx` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 8 | Per-channel request |
| chan_en | input | 8 | Per-channel enable; 0 masks the channel |
| chan_lvl | input | 32 | Packed 4-bit levels, channel i at bits 4i+3..4i |
| mode_rot | input | 1 | 0 = level-based order, 1 = channel-number order |
| xfer_done | input | 1 | Current transfer finished; releases the grant |
| grant | output | 8 | One-hot grant vector |
| grant_idx | output | 3 | Number of the granted channel |

## Verification
The hardest situation to reach from the ports is a grant that must stay fixed while a more urgent candidate shows up. A held grant looks the same as a fresh one, so the stimulus first lets a level-5 channel win. It then raises channel 0 at level 0, rewrites every level and drops all enables, all while `xfer_done` stays low. Each of those cycles must still show the original owner. After the release, a hand-picked sequence covers tie-breaking, masking and the channel-number mode. A randomized phase compares each win against a model that scans levels from 0 upward.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

    localparam int ARB_CH    = 8;
    localparam int ARB_LVL_W = 4;
    localparam int ARB_IDX_W = $clog2(ARB_CH);

    typedef enum logic {
        ORDER_LEVEL = 1'b0,
        ORDER_INDEX = 1'b1
    } order_mode_e;

    typedef struct packed {
        logic                 valid;
        logic [ARB_IDX_W-1:0] idx;
    } arb_pick_t;

    function automatic logic [ARB_CH-1:0] idx_to_onehot(input logic [ARB_IDX_W-1:0] idx);
        logic [ARB_CH-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/prio_arb_select.sv
module prio_arb_select
    import prio_arb_pkg::*;
#(
    parameter int N_CH  = ARB_CH,
    parameter int LVL_W = ARB_LVL_W,
    localparam int IW   = $clog2(N_CH)
) (
    input  logic [N_CH-1:0]       cand,
    input  logic [N_CH*LVL_W-1:0] lvl_flat,
    input  order_mode_e           order,
    output logic                  pick_valid,
    output logic [IW-1:0]         pick_idx
);

    logic [LVL_W-1:0] lvl_arr [N_CH];

    for (genvar g = 0; g < N_CH; g++) begin : g_unpack
        assign lvl_arr[g] = lvl_flat[g*LVL_W +: LVL_W];
    end

    // Scan from the top channel down; a later (lower) channel replaces the
    // current choice when its level is no worse, so ties fall to the lowest.
    always_comb begin
        logic [LVL_W-1:0] best;
        best       = '1;
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (cand[i] && (order == ORDER_INDEX || lvl_arr[i] <= best)) begin
                pick_valid = 1'b1;
                pick_idx   = IW'(i);
                best       = lvl_arr[i];
            end
        end
    end

endmodule

// File: rtl/prio_arb_hold.sv
module prio_arb_hold
    import prio_arb_pkg::*;
#(
    parameter int N_CH = ARB_CH,
    localparam int IW  = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pick_valid,
    input  logic [IW-1:0]   pick_idx,
    input  logic            xfer_done,
    output logic [N_CH-1:0] grant,
    output logic [IW-1:0]   grant_idx
);

    logic          busy_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (busy_q) begin
            if (xfer_done) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end
        end else if (pick_valid) begin
            busy_q <= 1'b1;
            idx_q  <= pick_idx;
        end
    end

    always_comb begin
        grant = '0;
        if (busy_q) grant[idx_q] = 1'b1;
    end
    assign grant_idx = idx_q;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && !xfer_done) |=> ($stable(grant) && $stable(grant_idx))); // R4
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && xfer_done) |=> (grant == '0)); // R5
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R7
    AST_IDX_AGREES: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> grant[grant_idx]); // R7
    AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
        (grant == '0) |-> (grant_idx == '0)); // R7

endmodule

// File: rtl/prio_level_arbiter.sv
module prio_level_arbiter
    import prio_arb_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ARB_CH-1:0]           req,
    input  logic [ARB_CH-1:0]           chan_en,
    input  logic [ARB_CH*ARB_LVL_W-1:0] chan_lvl,
    input  logic                        mode_rot,
    input  logic                        xfer_done,
    output logic [ARB_CH-1:0]           grant,
    output logic [ARB_IDX_W-1:0]        grant_idx
);

    logic [ARB_CH-1:0] cand;
    arb_pick_t         pick;
    order_mode_e       order;

    assign cand  = req & chan_en;
    assign order = mode_rot ? ORDER_INDEX : ORDER_LEVEL;

    prio_arb_select #(
        .N_CH  (ARB_CH),
        .LVL_W (ARB_LVL_W)
    ) u_select (
        .cand       (cand),
        .lvl_flat   (chan_lvl),
        .order      (order),
        .pick_valid (pick.valid),
        .pick_idx   (pick.idx)
    );

    prio_arb_hold #(
        .N_CH (ARB_CH)
    ) u_hold (
        .clk        (clk),
        .rst        (rst),
        .pick_valid (pick.valid),
        .pick_idx   (pick.idx),
        .xfer_done  (xfer_done),
        .grant      (grant),
        .grant_idx  (grant_idx)
    );

    // A fresh grant must go to a channel that was an enabled requester.
    AST_GRANT_FROM_CAND: assert property (@(posedge clk) disable iff (rst)
        (grant == '0) |=> (grant == '0 || (($past(cand) & grant) != '0))); // R3
    AST_IDLE_NO_CAND: assert property (@(posedge clk) disable iff (rst)
        (grant == '0 && cand == '0) |=> (grant == '0)); // R7

endmodule

// File: tb/prio_level_arbiter_test.sv
module prio_level_arbiter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  req = '0;
    logic [7:0]  chan_en = '0;
    logic [31:0] chan_lvl = '0;
    logic        mode_rot = 1'b0;
    logic        xfer_done = 1'b0;
    logic [7:0]  grant;
    logic [2:0]  grant_idx;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] g;
        logic [2:0] i;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    prio_level_arbiter uut (
        .clk(clk), .rst(rst), .req(req), .chan_en(chan_en),
        .chan_lvl(chan_lvl), .mode_rot(mode_rot), .xfer_done(xfer_done),
        .grant(grant), .grant_idx(grant_idx)
    );

    task automatic check(input logic [7:0] g, input logic [2:0] i, input string tag);
        checks++;
        if (grant !== g || grant_idx !== i) begin
            errors++;
            $display("FAIL %s: grant=%b idx=%0d expected grant=%b idx=%0d",
                     tag, grant, grant_idx, g, i);
        end
    endtask

    // Monitor: mid-high phase after each edge, compare against queued item.
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.g, e.i, e.tag);
        end
    end

    // Driver: apply one cycle of inputs and queue the result after the edge.
    task automatic step(input logic [7:0] r, input logic [7:0] e, input logic [31:0] l,
                        input logic m, input logic d,
                        input logic [7:0] eg, input logic [2:0] ei, input string tag);
        exp_t x;
        @(negedge clk);
        req = r; chan_en = e; chan_lvl = l; mode_rot = m; xfer_done = d;
        x.g = eg; x.i = ei; x.tag = tag;
        exp_q.push_back(x);
    endtask

    // Reference: scan levels from most urgent, channels from lowest.
    function automatic int model_pick(input logic [7:0] c, input logic [31:0] l, input logic m);
        if (m) begin
            for (int i = 0; i < 8; i++) if (c[i]) return i;
            return -1;
        end
        for (int lv = 0; lv < 16; lv++)
            for (int i = 0; i < 8; i++)
                if (c[i] && l[4*i +: 4] == 4'(lv)) return i;
        return -1;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #5 check(8'h00, 3'd0, "R8 reset");
        @(negedge clk) rst = 1'b0;

        // R1: ch2 level 3 vs ch6 level 1
        step(8'h44, 8'hFF, 32'hF1FF_F3FF, 0, 0, 8'h40, 3'd6, "R1 lower level wins");
        step(8'h44, 8'hFF, 32'hF1FF_F3FF, 0, 1, 8'h00, 3'd0, "R5 done clears");
        step(8'h00, 8'hFF, 32'h0, 0, 0, 8'h00, 3'd0, "R7 no request idle");

        // R2: ch1 and ch5 at level 7
        step(8'h22, 8'hFF, 32'h0070_0070, 0, 0, 8'h02, 3'd1, "R2 tie to lowest channel");
        step(8'h00, 8'hFF, 32'h0, 0, 1, 8'h00, 3'd0, "R5 done clears");
        step(8'h22, 8'hFF, 32'h0060_0070, 0, 0, 8'h20, 3'd5, "R1 ch5 level 6 beats ch1 level 7");
        step(8'h00, 8'hFF, 32'h0, 0, 1, 8'h00, 3'd0, "R5 done clears");

        // R3: masked channel 0 at level 0
        step(8'h11, 8'hFE, 32'h0009_0000, 0, 0, 8'h10, 3'd4, "R3 disabled channel skipped");
        step(8'h00, 8'hFF, 32'h0, 0, 1, 8'h00, 3'd0, "R5 done clears");
        step(8'hFF, 8'h00, 32'h0, 0, 0, 8'h00, 3'd0, "R3 all disabled no grant");

        // R4: hold against more urgent requester and input changes
        step(8'h08, 8'hFF, 32'h0000_5000, 0, 0, 8'h08, 3'd3, "R4 initial owner");
        step(8'h01, 8'hFF, 32'h0000_0000, 0, 0, 8'h08, 3'd3, "R4 held vs level 0 ch0");
        step(8'h01, 8'hFF, 32'h0000_0000, 1, 0, 8'h08, 3'd3, "R4 held vs mode change");
        step(8'h00, 8'h00, 32'hFFFF_FFFF, 0, 0, 8'h08, 3'd3, "R4 held with no enables");
        step(8'h01, 8'hFF, 32'h0000_0000, 0, 1, 8'h00, 3'd0, "R5 done releases");
        step(8'h01, 8'hFF, 32'h0000_0000, 0, 0, 8'h01, 3'd0, "R5 next winner one cycle later");
        step(8'h00, 8'hFF, 32'h0, 0, 1, 8'h00, 3'd0, "R5 done clears");

        // R6: index order ignores levels
        step(8'h26, 8'hFF, 32'h00F0_00F0, 1, 0, 8'h02, 3'd1, "R6 lowest index despite level 15");
        step(8'h26, 8'hFF, 32'h00F0_00F0, 1, 1, 8'h00, 3'd0, "R5 done clears");
        step(8'h26, 8'hFF, 32'h00F0_00F0, 0, 0, 8'h04, 3'd2, "R1 same inputs in level mode");
        step(8'h26, 8'hFF, 32'h00F0_00F0, 0, 1, 8'h00, 3'd0, "R5 done clears");
        step(8'h26, 8'hFD, 32'h00F0_00F0, 1, 0, 8'h04, 3'd2, "R6 R3 masked ch1 in index mode");
        step(8'h00, 8'hFF, 32'h0, 0, 1, 8'h00, 3'd0, "R5 done clears");

        // Randomized rounds against the reference
        for (int k = 0; k < 60; k++) begin
            logic [7:0]  r, e;
            logic [31:0] l;
            logic        m;
            int          w;
            r = 8'($urandom); e = 8'($urandom); l = $urandom; m = ($urandom % 4) == 0;
            w = model_pick(r & e, l, m);
            if (w < 0) step(r, e, l, m, 0, 8'h00, 3'd0, "R7 random no candidate");
            else step(r, e, l, m, 0, 8'(1 << w), 3'(w), m ? "R6 random" : "R1 R2 random");
            step(r, e, l, m, 1, 8'h00, 3'd0, "R5 random release");
        end

        repeat (3) @(posedge clk);
        #6;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule